// File: doc/BRIEF.md
# Boot-Time Clock Input Selector

This block brings up the sampling-clock distribution chip before the rest of the device is allowed out of reset. It runs from an auxiliary clock that never stops, even when the main logic is fed from an off-board source. A qualifying flag, such as a clock-generator lock, marks that clock as usable. Once the flag is high, the block reads two configuration switches through a synchronizer. It then sends a fixed list of four single-byte register writes to the distribution chip over a four-wire SPI link. No software takes part.

One entry of the write list carries the clock-input choice. When both switches read 0, that entry selects the external (off-board) input. Every other switch setting selects the on-board input. The last entry commits the written settings inside the chip. A `clocks_invalid` output holds downstream logic in reset from power-up until the last write has fully left the link. If the qualifying flag drops at any time, the block abandons the current transfer, raises `clocks_invalid` again, and starts over from the first entry when the flag returns.

Inside the block, the sequencer hands each 24-bit frame to the serial engine over a valid/ready handshake. The sequencer holds the frame and its valid until the engine is idle and accepts it, so the engine applies back-pressure for a whole transfer plus the chip-select gap. The external pins are plain control lines.

Top module: `clksel_boot_seq`

## Requirements
- R1: During and right after reset, `clocks_invalid` is 1, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: While `aux_valid` is 0, no transfer begins, and in the cycle after `aux_valid` is seen low, `spi_cs_n` and `clocks_invalid` are both 1.
- R3: Once `aux_valid` is 1, exactly four frames are sent without further stimulus, in this order of (address, data): (0x000, 0x10), (0x045, switch-selected byte), (0x058, 0x20), (0x05A, 0x01). The last one is the commit command.
- R4: Each frame has 24 bits and is sent MSB first. Bit 23 is 0 (write), bits 22:21 are 00 (one data byte), bits 20:8 hold the 13-bit register address and bits 7:0 hold the data byte.
- R5: The link uses mode 0. `spi_sclk` is low whenever `spi_cs_n` is high, `spi_mosi` never changes while `spi_sclk` is high, and one `spi_sclk` period lasts SCLK_DIV auxiliary clock cycles (default 8).
- R6: Between two transfers, and between reset and the first transfer, `spi_cs_n` stays high for at least CS_GAP*SCLK_DIV auxiliary cycles (default 16).
- R7: If `cfg_sw` is 2'b00, the second entry's data byte is 0x1A (external input). For 2'b01, 2'b10 and 2'b11 it is 0x1D (on-board input).
- R8: The switches are captured once, when a sequence starts. A change of `cfg_sw` during the sequence does not alter any frame of that sequence.
- R9: `clocks_invalid` stays 1 while any frame is on the link and falls only after the fourth frame's chip select has returned high. It then stays 0 and no further frame is sent while `aux_valid` stays 1.
- R10: If `aux_valid` falls mid-transfer, chip select is released on the next cycle and the partial frame is dropped. When `aux_valid` returns, the full sequence is sent again from the first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running auxiliary clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| aux_valid | input | 1 | Qualifies the auxiliary clock; synchronous to clk |
| cfg_sw | input | 2 | Configuration switches (asynchronous) |
| spi_cs_n | output | 1 | Active-low chip select to the distribution chip |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the chip |
| spi_miso | input | 1 | Serial data from the chip (unused by the write-only sequence) |
| clocks_invalid | output | 1 | High holds the rest of the design in reset |

## Verification
The bench decodes every frame like a slave would, sampling on rising SCLK, and compares each frame against the entry list for all four switch settings. A wrong switch decode or a swapped address or data field shows up as a mismatched frame. A flipped mode-0 edge shows up either as a shifted frame or as MOSI moving while SCLK is high. The bench flips the switches in the middle of a sequence to catch a design that samples them continuously instead of once. It also drops the valid flag in the middle of a frame and checks three things: the chip select is released at once, the partial frame is left short, and the rerun starts at the first entry rather than resuming. The bench checks `clocks_invalid` against the chip select and measures the chip-select gaps. An early release of reset, or back-to-back frames, is reported as a bad gap or as an invalid-low observation while a frame is on the link.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

  localparam int ADDR_W  = 13;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = 3 + ADDR_W + DATA_W;
  localparam int N_ENTRY = 4;
  localparam int SEL_IDX = 1;

  localparam logic [DATA_W-1:0] SEL_EXT_BYTE = 8'h1A;
  localparam logic [DATA_W-1:0] SEL_INT_BYTE = 8'h1D;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_entry_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT, SQ_DONE} seq_state_t;
  typedef enum logic [1:0] {EN_GAP, EN_IDLE, EN_SHIFT, EN_HOLD} eng_state_t;

  // Boot write list; the clock-input entry takes its byte from the switch decode.
  function automatic wr_entry_t rom_entry(input int unsigned idx, input logic use_ext);
    wr_entry_t e;
    case (idx)
      0:       e = '{addr: 13'h000, data: 8'h10};
      SEL_IDX: e = '{addr: 13'h045, data: (use_ext ? SEL_EXT_BYTE : SEL_INT_BYTE)};
      2:       e = '{addr: 13'h058, data: 8'h20};
      default: e = '{addr: 13'h05A, data: 8'h01};
    endcase
    return e;
  endfunction

  // Write instruction: R/W=0, length=00 (one byte), address, then data.
  function automatic logic [FRAME_W-1:0] build_frame(input wr_entry_t e);
    return {1'b0, 2'b00, e.addr, e.data};
  endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign d_sync = sync_q;
endmodule

// File: rtl/clksel_seq.sv
module clksel_seq
  import clksel_pkg::*;
#(
  parameter int NUM_ENTRY = N_ENTRY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_in,
  input  logic [1:0]         sw_sync,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [FRAME_W-1:0] req_frame,
  output logic               abort,
  output logic               clocks_invalid
);
  localparam int IDX_W = (NUM_ENTRY > 1) ? $clog2(NUM_ENTRY) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRY - 1);

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic             ext_q;
  logic             inv_q;

  always_comb begin
    st_d = st_q;
    if (!valid_in) begin
      st_d = SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE:  st_d = SQ_ISSUE;
        SQ_ISSUE: if (req_ready) st_d = SQ_WAIT;
        SQ_WAIT:  if (req_ready) st_d = (idx_q == LAST_IDX) ? SQ_DONE : SQ_ISSUE;
        default:  st_d = SQ_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      idx_q <= '0;
      ext_q <= 1'b0;
      inv_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      inv_q <= (st_d != SQ_DONE);
      if (st_q == SQ_IDLE) begin
        idx_q <= '0;
        ext_q <= (sw_sync == 2'b00);
      end else if (valid_in && st_q == SQ_WAIT && req_ready && idx_q != LAST_IDX) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign req_valid      = valid_in && (st_q == SQ_ISSUE);
  assign req_frame      = build_frame(rom_entry(int'(idx_q), ext_q));
  assign abort          = !valid_in;
  assign clocks_invalid = inv_q;
endmodule

// File: rtl/clksel_spi_wr.sv
module clksel_spi_wr
  import clksel_pkg::*;
#(
  parameter int FW       = FRAME_W,
  parameter int SCLK_DIV = 8,
  parameter int CS_GAP   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [FW-1:0] req_frame,
  input  logic          abort,
  output logic          spi_cs_n,
  output logic          spi_sclk,
  output logic          spi_mosi
);
  localparam int HALF    = SCLK_DIV / 2;
  localparam int GAP_CYC = CS_GAP * SCLK_DIV;
  localparam int CNT_W   = $clog2(GAP_CYC + HALF + 1);
  localparam int BIT_W   = $clog2(FW);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_END  = BIT_W'(FW - 1);

  eng_state_t       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic [FW-1:0]    sh_q;
  logic             cs_n_q;
  logic             sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EN_GAP;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
    end else if (abort && (st_q == EN_SHIFT || st_q == EN_HOLD)) begin
      st_q   <= EN_GAP;
      cnt_q  <= '0;
      cs_n_q <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      case (st_q)
        EN_GAP: begin
          if (cnt_q == GAP_END) begin
            st_q  <= EN_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        EN_IDLE: begin
          if (req_valid) begin
            sh_q   <= req_frame;
            cs_n_q <= 1'b0;
            sclk_q <= 1'b0;
            cnt_q  <= '0;
            bit_q  <= '0;
            st_q   <= EN_SHIFT;
          end
        end
        EN_SHIFT: begin
          if (cnt_q == HALF_END) begin
            cnt_q <= '0;
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == BIT_END) begin
                st_q <= EN_HOLD;
              end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= sh_q << 1;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          if (cnt_q == HALF_END) begin
            cs_n_q <= 1'b1;
            cnt_q  <= '0;
            st_q   <= EN_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign req_ready = (st_q == EN_IDLE);
  assign spi_cs_n  = cs_n_q;
  assign spi_sclk  = sclk_q;
  assign spi_mosi  = sh_q[FW-1];
endmodule

// File: rtl/clksel_boot_seq.sv
module clksel_boot_seq
  import clksel_pkg::*;
#(
  parameter int SCLK_DIV = 8,
  parameter int CS_GAP   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       aux_valid,
  input  logic [1:0] cfg_sw,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       clocks_invalid
);
  logic [1:0]         sw_sync;
  logic               req_valid;
  logic               req_ready;
  logic [FRAME_W-1:0] req_frame;
  logic               abort;
  logic               unused_miso;

  assign unused_miso = spi_miso;

  clksel_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cfg_sw),
    .d_sync  (sw_sync)
  );

  clksel_seq #(.NUM_ENTRY(N_ENTRY)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_in       (aux_valid),
    .sw_sync        (sw_sync),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_frame      (req_frame),
    .abort          (abort),
    .clocks_invalid (clocks_invalid)
  );

  clksel_spi_wr #(.FW(FRAME_W), .SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP)) u_spi (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_frame (req_frame),
    .abort     (abort),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
  );
endmodule

// File: rtl/clksel_boot_seq_chk.sv
module clksel_boot_seq_chk #(
  parameter int SCLK_DIV = 8,
  parameter int CS_GAP   = 2
) (
  input logic clk,
  input logic rst_n,
  input logic aux_valid,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic clocks_invalid
);
  localparam int GAP_CYC = CS_GAP * SCLK_DIV;
  localparam int HC_W    = 16;

  logic [HC_W-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= '0;
    else if (!spi_cs_n)      hi_cnt <= '0;
    else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 1'b1;
  end

  a_r2_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !aux_valid |=> (spi_cs_n && clocks_invalid));

  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  a_r5_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> $stable(spi_mosi));

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (32'(hi_cnt) >= GAP_CYC));

  a_r9_quiet_when_released: assert property (@(posedge clk) disable iff (!rst_n)
    !clocks_invalid |-> spi_cs_n);
endmodule

bind clksel_boot_seq clksel_boot_seq_chk #(.SCLK_DIV(SCLK_DIV), .CS_GAP(CS_GAP)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .aux_valid      (aux_valid),
  .spi_cs_n       (spi_cs_n),
  .spi_sclk       (spi_sclk),
  .spi_mosi       (spi_mosi),
  .clocks_invalid (clocks_invalid)
);

// File: tb/clksel_boot_seq_test.sv
`timescale 1ns/1ps
module clksel_boot_seq_test;
  localparam int CLK_PERIOD = 5;
  localparam int DIV = 8;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic aux_valid = 1'b0;
  logic [1:0] cfg_sw = 2'b00;
  logic spi_miso = 1'b0;
  logic spi_cs_n, spi_sclk, spi_mosi, clocks_invalid;

  always #(CLK_PERIOD/2.0) clk = ~clk;

  clksel_boot_seq #(.SCLK_DIV(DIV), .CS_GAP(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .aux_valid(aux_valid), .cfg_sw(cfg_sw),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .clocks_invalid(clocks_invalid)
  );

  int n_checks = 0;
  int n_fail = 0;

  // Slave-side observer
  int frame_n, hi_cnt, min_gap, per_cnt, min_per, max_per, mosi_bad, inv_bad, bc;
  logic [23:0] frames [0:15];
  int fbits [0:15];
  logic [23:0] sh;
  logic p_cs = 1'b1, p_sclk = 1'b0, p_mosi = 1'b0;
  bit seen_rise;

  task automatic clear_log();
    @(posedge clk); #1;
    frame_n = 0; min_gap = 1000000; min_per = 1000000; max_per = 0;
    mosi_bad = 0; inv_bad = 0;
  endtask

  always @(negedge clk) begin
    if (p_cs && !spi_cs_n) begin
      if (hi_cnt < min_gap) min_gap = hi_cnt;
      sh = '0; bc = 0; seen_rise = 0; per_cnt = 0;
    end
    if (!spi_cs_n) begin
      if (spi_sclk && p_sclk && spi_mosi != p_mosi) mosi_bad++;
      if (!clocks_invalid) inv_bad++;
      per_cnt++;
      if (spi_sclk && !p_sclk) begin
        sh = {sh[22:0], spi_mosi};
        bc++;
        if (seen_rise) begin
          if (per_cnt < min_per) min_per = per_cnt;
          if (per_cnt > max_per) max_per = per_cnt;
        end
        per_cnt = 0;
        seen_rise = 1;
      end
      hi_cnt = 0;
    end else begin
      hi_cnt++;
    end
    if (!p_cs && spi_cs_n) begin
      if (frame_n < 16) begin
        frames[frame_n] = sh;
        fbits[frame_n] = bc;
      end
      frame_n++;
    end
    p_cs = spi_cs_n; p_sclk = spi_sclk; p_mosi = spi_mosi;
  end

  function automatic logic [23:0] exp_frame(input int i, input bit ext);
    logic [12:0] a;
    logic [7:0] d;
    case (i)
      0: begin a = 13'h000; d = 8'h10; end
      1: begin a = 13'h045; d = ext ? 8'h1A : 8'h1D; end
      2: begin a = 13'h058; d = 8'h20; end
      default: begin a = 13'h05A; d = 8'h01; end
    endcase
    return {1'b0, 2'b00, a, d};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_true(input string req, input string what, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; aux_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (clocks_invalid && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "sequence completes", clocks_invalid, 0);
  endtask

  task automatic check_list(input string req, input bit ext);
    chk("R3", "frame count", frame_n, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R4", $sformatf("frame %0d bit count", i), fbits[i], 24);
      chk(req, $sformatf("frame %0d content", i), frames[i], exp_frame(i, ext));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; aux_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "invalid in reset", clocks_invalid, 1);
    chk("R1", "cs_n in reset", spi_cs_n, 1);
    chk("R1", "sclk in reset", spi_sclk, 0);
    rst_n = 1'b1;
    clear_log();
    repeat (300) @(negedge clk);
    chk("R2", "no frame while valid low", frame_n, 0);
    chk("R2", "cs_n high while valid low", spi_cs_n, 1);
    chk("R1", "invalid held after reset", clocks_invalid, 1);
  endtask

  task automatic t_boot(input logic [1:0] sw);
    bit ext = (sw == 2'b00);
    do_reset();
    cfg_sw = sw;
    repeat (5) @(negedge clk);
    clear_log();
    @(negedge clk);
    aux_valid = 1'b1;
    wait_done("R9");
    check_list("R7", ext);
    chk("R9", "cs_n high at release", spi_cs_n, 1);
    chk("R9", "invalid low while frame active", inv_bad, 0);
    chk_true("R6", "cs gap", min_gap >= GAP*DIV, min_gap, GAP*DIV);
    chk("R5", "sclk min period", min_per, DIV);
    chk("R5", "sclk max period", max_per, DIV);
    chk("R5", "mosi moved while sclk high", mosi_bad, 0);
    repeat (500) @(negedge clk);
    chk("R9", "no frames after release", frame_n, 4);
    chk("R9", "invalid stays low", clocks_invalid, 0);
  endtask

  task automatic t_sw_change();
    int n = 0;
    do_reset();
    cfg_sw = 2'b00;
    repeat (5) @(negedge clk);
    clear_log();
    @(negedge clk);
    aux_valid = 1'b1;
    while (frame_n < 1 && n < 5000) begin @(negedge clk); n++; end
    cfg_sw = 2'b11;
    wait_done("R8");
    check_list("R8", 1'b1);
  endtask

  task automatic t_abort();
    int n = 0;
    do_reset();
    cfg_sw = 2'b10;
    repeat (5) @(negedge clk);
    clear_log();
    @(negedge clk);
    aux_valid = 1'b1;
    while (frame_n < 1 && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    while (spi_cs_n && n < 5000) begin @(negedge clk); n++; end
    repeat (40) @(negedge clk);
    aux_valid = 1'b0;
    @(negedge clk);
    chk("R10", "cs released next cycle", spi_cs_n, 1);
    chk("R10", "invalid reasserted", clocks_invalid, 1);
    repeat (100) @(negedge clk);
    chk("R10", "partial frame logged", frame_n, 2);
    chk_true("R10", "partial frame short", fbits[1] < 24, fbits[1], 23);
    chk("R2", "quiet while valid low", spi_cs_n, 1);
    clear_log();
    @(negedge clk);
    aux_valid = 1'b1;
    wait_done("R10");
    check_list("R10", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    hi_cnt = 0; frame_n = 0; per_cnt = 0; bc = 0; sh = '0; seen_rise = 0;
    min_gap = 1000000; min_per = 1000000; max_per = 0; mosi_bad = 0; inv_bad = 0;
    t_reset();
    t_boot(2'b00);
    t_boot(2'b01);
    t_boot(2'b10);
    t_boot(2'b11);
    t_sw_change();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule